// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the five machine-level control and status registers a minimal 64-bit core needs. It executes the two CSR instructions the core issues, read-write and read-set, and it sequences trap entry and the return-from-trap. The core presents one CSR access per cycle with a 12-bit address, an operation and a source operand. It gets the old register value back in the same cycle, and the write takes effect at the next clock edge.

Traps come from two sources. An exception request arrives with its own cause and faulting PC. A single external interrupt line is taken only when the machine interrupt-enable bit is set. Either source, and a return request, produce a redirect strobe and a target PC in the same cycle. The register updates (cause, exception PC, interrupt-enable stacking) land on the next edge. The address-translation register is decoded into a translation-enable flag and a root page-table byte address for an external translator. Any access to an address outside the five implemented ones raises an illegal flag and changes nothing.

Top module: `mcsr_unit`

## Requirements
- R1: After reset the status register reads 0x000C0100, and the vector, exception PC, cause and translation registers read zero. Redirect, interrupt acknowledge and illegal outputs are low.
- R2: The implemented addresses are 0x300 (status), 0x305 (trap vector), 0x341 (exception PC), 0x342 (cause) and 0x180 (translation). An access to any of them returns the register's current value on `csr_rdata_o` in the same cycle.
- R3: With `csr_op_i`=0 (read-write), the source operand replaces the register at the next edge, subject to R5.
- R4: With `csr_op_i`=1 (read-set), the source operand is ORed into the register at the next edge, subject to R5. A zero operand therefore leaves the register unchanged.
- R5: In the status register only bits 0,1,3,4,5,7,8,12:11 and 19:18 (mask 0x000C19BB) hold written values. Every other bit ignores writes and reads as zero. MIE is bit 3 and MPIE is bit 7.
- R6: An access to any other address below 4096 raises `illegal_o` in that cycle and returns zero data. No register changes.
- R7: When `trap_i` is high, the block raises `redirect_o` in that cycle with `redirect_pc_o` equal to the trap vector register. At the next edge the cause register takes `trap_cause_i`, the exception PC register takes `trap_pc_i`, MPIE takes the old MIE, and MIE clears.
- R8: When `mret_i` is high, the block redirects to the exception PC register in that cycle. At the next edge MIE takes the old MPIE and MPIE becomes 1.
- R9: When `ext_irq_i` is high, MIE is 1, and neither a trap nor a return is requested, the interrupt is taken. `irq_ack_o` goes high and the block redirects to the trap vector. The trap entry of R7 follows with cause 0x80000005 and exception PC equal to `cur_pc_i`. With MIE at 0 the line has no effect.
- R10: In a cycle where a trap, interrupt or return is taken, the CSR write of that cycle is dropped, but the old value is still returned. An exception request takes precedence over the interrupt.
- R11: `xlat_en_o` is high whenever the translation register's bits 63:60 are nonzero. `satp_mode_o` carries those four bits, and `root_base_o` equals bits 43:0 shifted left by 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_en_i | input | 1 | CSR access valid this cycle |
| csr_op_i | input | 1 | 0 = read-write, 1 = read-set |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | Source operand |
| csr_rdata_o | output | 64 | Old value of the addressed register |
| illegal_o | output | 1 | Access to an unimplemented address |
| trap_i | input | 1 | Exception trap request |
| trap_cause_i | input | 64 | Exception cause |
| trap_pc_i | input | 64 | Faulting PC |
| mret_i | input | 1 | Return-from-trap request |
| ext_irq_i | input | 1 | External interrupt pending |
| cur_pc_i | input | 64 | PC saved when the interrupt is taken |
| irq_ack_o | output | 1 | Interrupt taken; clears the pending request |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 64 | Redirect target |
| xlat_en_o | output | 1 | Address translation enabled |
| satp_mode_o | output | 4 | Translation mode field |
| root_base_o | output | 56 | Root page-table byte address |

## Verification
The assertions assume the core never raises `trap_i` and `mret_i` in the same cycle, and one property checks that assumption at the inputs. Each stimulus task raises at most one of these requests per cycle. The write, stacking and hold properties look one edge back and assume the inputs are steady through the cycle. The bench therefore changes every input on the falling edge and holds it until the next one, and it combines a CSR access with a flow request only in the cycles that target R10.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int XLEN       = 64;
  localparam int ADDR_W     = 12;
  localparam int N_CSR      = 5;
  localparam int PPN_W      = 44;
  localparam int MODE_W     = 4;
  localparam int PAGE_SHIFT = 12;
  localparam int BASE_W     = PPN_W + PAGE_SHIFT;

  localparam int I_MSTATUS = 0;
  localparam int I_MTVEC   = 1;
  localparam int I_MEPC    = 2;
  localparam int I_MCAUSE  = 3;
  localparam int I_SATP    = 4;

  localparam int MIE_BIT  = 3;
  localparam int MPIE_BIT = 7;

  localparam logic [XLEN-1:0] MSTATUS_WMASK = 64'h0000_0000_000C_19BB;
  localparam logic [XLEN-1:0] MSTATUS_RST   = 64'h0000_0000_000C_0100;
  localparam logic [XLEN-1:0] IRQ_CAUSE     = 64'h0000_0000_8000_0005;

  localparam logic [ADDR_W-1:0] CSR_ADDR [N_CSR] =
    '{12'h300, 12'h305, 12'h341, 12'h342, 12'h180};
  localparam logic [XLEN-1:0] CSR_RST [N_CSR] =
    '{MSTATUS_RST, '0, '0, '0, '0};
  localparam logic [XLEN-1:0] CSR_WMASK [N_CSR] =
    '{MSTATUS_WMASK, '1, '1, '1, '1};

  typedef enum logic {
    CSR_RW = 1'b0,
    CSR_RS = 1'b1
  } csr_op_e;
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_CSR-1:0]  sel_o,
  output logic              hit_o
);
  for (genvar g = 0; g < N_CSR; g++) begin : g_match
    assign sel_o[g] = (addr_i == CSR_ADDR[g]);
  end
  assign hit_o = |sel_o;
endmodule

// File: rtl/mcsr_trap_ctl.sv
module mcsr_trap_ctl
  import mcsr_pkg::*;
(
  input  logic            trap_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic            mret_i,
  input  logic            ext_irq_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic            mie_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] mepc_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic            irq_ack_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o
);
  logic irq_take;

  // exception wins over interrupt; return excludes interrupt
  assign irq_take      = ext_irq_i & mie_i & ~trap_i & ~mret_i;
  assign take_o        = trap_i | irq_take;
  assign cause_o       = trap_i ? trap_cause_i : IRQ_CAUSE;
  assign epc_o         = trap_i ? trap_pc_i : cur_pc_i;
  assign irq_ack_o     = irq_take;
  assign redirect_o    = take_o | mret_i;
  assign redirect_pc_o = take_o ? mtvec_i : mepc_i;
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
  import mcsr_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [N_CSR-1:0]            sel_i,
  input  logic                        wr_set_i,
  input  logic [XLEN-1:0]             wr_data_i,
  input  logic                        trap_i,
  input  logic [XLEN-1:0]             cause_i,
  input  logic [XLEN-1:0]             epc_i,
  input  logic                        mret_i,
  output logic [XLEN-1:0]             rdata_o,
  output logic [N_CSR-1:0][XLEN-1:0]  csr_o
);
  for (genvar g = 0; g < N_CSR; g++) begin : g_reg
    logic [XLEN-1:0] q, d, wval;

    assign wval = (wr_set_i ? (q | wr_data_i) : wr_data_i) & CSR_WMASK[g];

    always_comb begin
      d = q;
      if (g == I_MSTATUS && trap_i) begin
        d[MPIE_BIT] = q[MIE_BIT];
        d[MIE_BIT]  = 1'b0;
      end else if (g == I_MSTATUS && mret_i) begin
        d[MIE_BIT]  = q[MPIE_BIT];
        d[MPIE_BIT] = 1'b1;
      end else if (g == I_MCAUSE && trap_i) begin
        d = cause_i;
      end else if (g == I_MEPC && trap_i) begin
        d = epc_i;
      end else if (wr_en_i && sel_i[g]) begin
        d = wval;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= CSR_RST[g];
      else         q <= d;
    end

    assign csr_o[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CSR; i++)
      if (sel_i[i]) rdata_o = rdata_o | csr_o[i];
  end

  a_r3_rw_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_set_i && sel_i[I_MTVEC] && !trap_i
    |=> csr_o[I_MTVEC] == $past(wr_data_i));

  a_r4_rs_ors: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_set_i && sel_i[I_SATP]
    |=> csr_o[I_SATP] == ($past(csr_o[I_SATP]) | $past(wr_data_i)));

  a_r5_resv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o[I_MSTATUS] & ~MSTATUS_WMASK) == '0);

  a_r7_trap_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> !csr_o[I_MSTATUS][MIE_BIT]
           && csr_o[I_MSTATUS][MPIE_BIT] == $past(csr_o[I_MSTATUS][MIE_BIT])
           && csr_o[I_MCAUSE] == $past(cause_i)
           && csr_o[I_MEPC] == $past(epc_i));

  a_r8_mret_unstack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_i |=> csr_o[I_MSTATUS][MPIE_BIT]
           && csr_o[I_MSTATUS][MIE_BIT] == $past(csr_o[I_MSTATUS][MPIE_BIT]));
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_en_i,
  input  logic              csr_op_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              illegal_o,
  input  logic              trap_i,
  input  logic [XLEN-1:0]   trap_cause_i,
  input  logic [XLEN-1:0]   trap_pc_i,
  input  logic              mret_i,
  input  logic              ext_irq_i,
  input  logic [XLEN-1:0]   cur_pc_i,
  output logic              irq_ack_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              xlat_en_o,
  output logic [MODE_W-1:0] satp_mode_o,
  output logic [BASE_W-1:0] root_base_o
);
  logic [N_CSR-1:0]           sel;
  logic                       hit;
  logic [N_CSR-1:0][XLEN-1:0] csr_q;
  logic                       take;
  logic [XLEN-1:0]            cause, epc;
  logic                       wr_en;
  logic [PPN_W-1:0]           ppn;

  mcsr_decode u_decode (
    .addr_i (csr_addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  mcsr_trap_ctl u_trap (
    .trap_i        (trap_i),
    .trap_cause_i  (trap_cause_i),
    .trap_pc_i     (trap_pc_i),
    .mret_i        (mret_i),
    .ext_irq_i     (ext_irq_i),
    .cur_pc_i      (cur_pc_i),
    .mie_i         (csr_q[I_MSTATUS][MIE_BIT]),
    .mtvec_i       (csr_q[I_MTVEC]),
    .mepc_i        (csr_q[I_MEPC]),
    .take_o        (take),
    .cause_o       (cause),
    .epc_o         (epc),
    .irq_ack_o     (irq_ack_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

  // flow changes cancel the access's write
  assign wr_en     = csr_en_i & hit & ~redirect_o;
  assign illegal_o = csr_en_i & ~hit;

  mcsr_file u_file (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .sel_i     (sel),
    .wr_set_i  (csr_op_i),
    .wr_data_i (csr_wdata_i),
    .trap_i    (take),
    .cause_i   (cause),
    .epc_i     (epc),
    .mret_i    (mret_i),
    .rdata_o   (csr_rdata_o),
    .csr_o     (csr_q)
  );

  assign satp_mode_o = csr_q[I_SATP][XLEN-1 -: MODE_W];
  assign ppn         = csr_q[I_SATP][PPN_W-1:0];
  assign xlat_en_o   = |satp_mode_o;
  assign root_base_o = {ppn, {PAGE_SHIFT{1'b0}}};

  a_r8_no_trap_with_mret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_i && mret_i));

  a_r9_ack_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> csr_q[I_MSTATUS][MIE_BIT] && !trap_i && !mret_i);

  a_r6_illegal_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o && !redirect_o |=> $stable(csr_q));

  a_r10_flow_drops_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_en_i && sel[I_MTVEC] && redirect_o |=> $stable(csr_q[I_MTVEC]));
endmodule

// File: tb/tb_mcsr_unit.sv
`timescale 1ns/1ps
module tb_mcsr_unit;
  localparam real HALF = 2.5;
  localparam logic [63:0] WMASK = 64'h000C_19BB;

  logic        clk = 0, rst_n = 0;
  logic        csr_en = 0, csr_op = 0;
  logic [11:0] csr_addr = 0;
  logic [63:0] csr_wdata = 0, trap_cause = 0, trap_pc = 0, cur_pc = 0;
  logic        trap = 0, mret = 0, ext_irq = 0;
  logic [63:0] csr_rdata, redirect_pc;
  logic        illegal, irq_ack, redirect, xlat_en;
  logic [3:0]  satp_mode;
  logic [55:0] root_base;

  int checks = 0, errors = 0;
  logic [63:0] m_ms, m_tvec, m_epc, m_cause, m_satp;

  always #HALF clk = ~clk;

  mcsr_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_en_i(csr_en), .csr_op_i(csr_op),
    .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
    .illegal_o(illegal), .trap_i(trap), .trap_cause_i(trap_cause),
    .trap_pc_i(trap_pc), .mret_i(mret), .ext_irq_i(ext_irq), .cur_pc_i(cur_pc),
    .irq_ack_o(irq_ack), .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .xlat_en_o(xlat_en), .satp_mode_o(satp_mode), .root_base_o(root_base)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic legal(logic [11:0] a);
    return a == 12'h300 || a == 12'h305 || a == 12'h341 || a == 12'h342 || a == 12'h180;
  endfunction

  function automatic logic [63:0] model_get(logic [11:0] a);
    case (a)
      12'h300: return m_ms;
      12'h305: return m_tvec;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h180: return m_satp;
      default: return 64'h0;
    endcase
  endfunction

  task automatic model_put(logic [11:0] a, logic [63:0] v);
    case (a)
      12'h300: m_ms = v & WMASK;
      12'h305: m_tvec = v;
      12'h341: m_epc = v;
      12'h342: m_cause = v;
      12'h180: m_satp = v;
      default: ;
    endcase
  endtask

  task automatic idle();
    csr_en = 0; trap = 0; mret = 0; ext_irq = 0;
  endtask

  // one access: drive at falling edge, check combinational outputs, commit at rising edge
  task automatic access(string req, logic [11:0] a, logic op, logic [63:0] d);
    logic [63:0] old;
    @(negedge clk);
    idle();
    csr_en = 1; csr_addr = a; csr_op = op; csr_wdata = d;
    #1;
    old = model_get(a);
    chk({req, " rdata"}, csr_rdata, old);
    chk({req, " illegal"}, {63'b0, illegal}, {63'b0, ~legal(a)});
    if (legal(a)) model_put(a, op ? (old | d) : d);
    @(posedge clk);
  endtask

  task automatic read_all(string req);
    access(req, 12'h300, 1'b1, 64'h0);
    access(req, 12'h305, 1'b1, 64'h0);
    access(req, 12'h341, 1'b1, 64'h0);
    access(req, 12'h342, 1'b1, 64'h0);
    access(req, 12'h180, 1'b1, 64'h0);
  endtask

  task automatic model_trap(logic [63:0] c, logic [63:0] pc);
    logic mie;
    mie = m_ms[3];
    m_cause = c; m_epc = pc;
    m_ms[7] = mie; m_ms[3] = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    m_ms = 64'h000C_0100; m_tvec = 0; m_epc = 0; m_cause = 0; m_satp = 0;
    #12 rst_n = 1;

    // R1 reset state
    @(negedge clk); #1;
    chk("R1 redirect", {63'b0, redirect}, 64'h0);
    chk("R1 irq_ack", {63'b0, irq_ack}, 64'h0);
    chk("R1 illegal", {63'b0, illegal}, 64'h0);
    chk("R1 xlat_en", {63'b0, xlat_en}, 64'h0);
    read_all("R1 reset");

    // R2/R6 full address sweep, read then write all-ones
    for (int a = 0; a < 4096; a++) access("R2 R6 sweep read", a[11:0], 1'b1, 64'h0);
    for (int a = 0; a < 4096; a++)
      if (!legal(a[11:0])) access("R6 sweep write", a[11:0], 1'b0, '1);
    read_all("R6 state held");

    // R3 read-write with walking patterns on every register
    for (int b = 0; b < 64; b += 7) begin
      v = (64'h1 << b) ^ 64'hA5A5_0000_5A5A_0F0F;
      access("R3 rw", 12'h305, 1'b0, v);
      access("R3 rw", 12'h341, 1'b0, ~v);
      access("R3 rw", 12'h342, 1'b0, v);
      access("R3 rw", 12'h180, 1'b0, ~v);
      access("R5 rw mstatus", 12'h300, 1'b0, v);
    end
    read_all("R3 R5 readback");

    // R5 each single status bit
    for (int b = 0; b < 64; b++) begin
      access("R5 single bit", 12'h300, 1'b0, 64'h1 << b);
      access("R5 single bit read", 12'h300, 1'b1, 64'h0);
    end

    // R4 read-set accumulation
    access("R4 clear", 12'h305, 1'b0, 64'h0);
    for (int b = 0; b < 64; b += 9) access("R4 rs", 12'h305, 1'b1, 64'h3 << b);
    access("R4 rs mstatus", 12'h300, 1'b0, 64'h0);
    access("R4 rs mstatus", 12'h300, 1'b1, '1);
    read_all("R4 readback");

    // R11 translation fields for every mode value
    for (int m = 0; m < 16; m++) begin
      v = {m[3:0], 16'hBEEF, 44'h0_0123_4567_89A} ^ (64'h1 << (m * 2));
      access("R11 satp write", 12'h180, 1'b0, v);
      @(negedge clk); #1;
      chk("R11 xlat_en", {63'b0, xlat_en}, {63'b0, (m_satp[63:60] != 0)});
      chk("R11 mode", {60'b0, satp_mode}, {60'b0, m_satp[63:60]});
      chk("R11 root", {8'b0, root_base}, {8'b0, m_satp[43:0], 12'h0});
    end

    // R7 exception trap with MIE set and clear
    for (int k = 0; k < 2; k++) begin
      access("R7 set mtvec", 12'h305, 1'b0, 64'h8000_1000 + k * 64'h40);
      access("R7 set mstatus", 12'h300, 1'b0, k ? 64'h0 : 64'h8);
      @(negedge clk);
      idle(); trap = 1; trap_cause = 64'd2 + k; trap_pc = 64'h8000_0200 + k * 4;
      #1;
      chk("R7 redirect", {63'b0, redirect}, 64'h1);
      chk("R7 target", redirect_pc, m_tvec);
      chk("R7 no ack", {63'b0, irq_ack}, 64'h0);
      model_trap(trap_cause, trap_pc);
      @(posedge clk);
      read_all("R7 after trap");
    end

    // R8 return, from both MPIE values
    for (int k = 0; k < 2; k++) begin
      access("R8 set mstatus", 12'h300, 1'b0, k ? 64'h80 : 64'h8);
      access("R8 set mepc", 12'h341, 1'b0, 64'h8000_0400 + k * 8);
      @(negedge clk);
      idle(); mret = 1;
      #1;
      chk("R8 redirect", {63'b0, redirect}, 64'h1);
      chk("R8 target", redirect_pc, m_epc);
      m_ms[3] = m_ms[7]; m_ms[7] = 1'b1;
      @(posedge clk);
      access("R8 mstatus after", 12'h300, 1'b1, 64'h0);
    end

    // R9 interrupt gated off, then taken
    access("R9 mie off", 12'h300, 1'b0, 64'h80);
    access("R9 mtvec", 12'h305, 1'b0, 64'h8000_2000);
    @(negedge clk);
    idle(); ext_irq = 1; cur_pc = 64'h8000_0800;
    #1;
    chk("R9 gated ack", {63'b0, irq_ack}, 64'h0);
    chk("R9 gated redirect", {63'b0, redirect}, 64'h0);
    @(posedge clk);
    read_all("R9 gated state");
    access("R9 mie on", 12'h300, 1'b0, 64'h8);
    @(negedge clk);
    idle(); ext_irq = 1; cur_pc = 64'h8000_0900;
    #1;
    chk("R9 ack", {63'b0, irq_ack}, 64'h1);
    chk("R9 redirect", {63'b0, redirect}, 64'h1);
    chk("R9 target", redirect_pc, 64'h8000_2000);
    model_trap(64'h8000_0005, cur_pc);
    @(posedge clk);
    read_all("R9 after irq");

    // R10 trap plus write in the same cycle: write dropped, old value returned
    access("R10 mie on", 12'h300, 1'b0, 64'h8);
    @(negedge clk);
    idle(); trap = 1; trap_cause = 64'd11; trap_pc = 64'h8000_0A00;
    ext_irq = 1; cur_pc = 64'h8000_0B00;
    csr_en = 1; csr_addr = 12'h305; csr_op = 0; csr_wdata = 64'hDEAD_BEEF;
    #1;
    chk("R10 rdata old", csr_rdata, m_tvec);
    chk("R10 trap beats irq", {63'b0, irq_ack}, 64'h0);
    model_trap(64'd11, 64'h8000_0A00);
    @(posedge clk);
    read_all("R10 after");
    @(negedge clk);
    idle(); mret = 1;
    csr_en = 1; csr_addr = 12'h342; csr_op = 1; csr_wdata = '1;
    #1;
    m_ms[3] = m_ms[7]; m_ms[7] = 1'b1;
    @(posedge clk);
    read_all("R10 mret drops write");

    @(negedge clk); idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule